// File: doc/BRIEF.md
# Memory Access Port Burst Sequencer

This block sits between a host that wants to load or store runs of 32-bit words in target memory and a debug transaction engine that performs one debug-port or access-port transaction at a time. The host issues one request: a direction, an access-port number, a start address and a word count. The sequencer then selects the access port, loads the transfer-address register once, and issues one data-window access per word. It relies on the target to auto-increment the address after each access. Store data arrives on a valid/ready stream. Load data leaves on another valid/ready stream.

The sequencer keeps a copy of the last select value that the target acknowledged, and it skips the select write when the new value matches that copy. Access-port reads are posted: each data-window read returns the result of the read before it. The sequencer therefore discards the first returned value and ends every load with a read of the debug port's read-buffer register. A one-cycle done pulse reports the final status and the number of words completed.

Stream rules: a word on `wd_data` is consumed in the cycle in which `wd_valid` and `wd_ready` are both high. `wd_ready` is raised only while a store transaction can be handed to the engine. A word on `rd_data` stays stable with `rd_valid` high until `rd_ready` takes it. While that word is held, no further transaction is issued, so a slow reader stalls the burst and no word is lost.

Top module: `mem_burst_seq`

## Requirements
- R1: The select value is (port << 24) | (register address & 0xF0), which is port << 24 for the window registers. It is written as a debug-port write with A=2'b10 (address 0x8), and only when it differs from the cached copy.
- R2: Reset sets the cached select copy to all ones, so the first burst after reset always writes the select register.
- R3: The cached copy is updated only when the select write returns OK (ack 3'b001). After a failed select write, the next burst writes the select register again.
- R4: A burst with a non-zero count issues exactly one access-port write with A=2'b01 (address 0x04) carrying the start address. It then issues count access-port accesses with A=2'b11 (address 0x0C). No request is accepted while a burst is running.
- R5: Access-port transactions drive `txn_apndp`=1 and debug-port transactions drive 0. `txn_a` carries register address bits [3:2], and `txn_rnw` is 1 for reads. A transaction is held stable until `txn_ready` accepts it.
- R6: In a store burst, each data-window write carries the next `wd_data` word in stream order. The word is consumed in the same cycle in which the transaction is accepted.
- R7: In a load burst, the first data-window result is discarded and a final debug-port read with A=2'b11 (address 0xC) collects the last word. The words leave on `rd_data` in address order. `rd_valid` is held with stable data until `rd_ready`, and no transaction is issued while a word is held.
- R8: The burst stops at the first response whose ack is not 3'b001 (3'b010 wait, 3'b100 fault, anything else a protocol error). `done_status` reports that ack, or 3'b001 on success, and `done_words` reports the words stored or delivered.
- R9: A request with a count of zero completes with status 3'b001 and zero words, and it issues no transaction.
- R10: `done` is a single-cycle pulse. `req_ready` is high in the same cycle, so a request held waiting is accepted at that edge.
- R11: After reset, `req_ready` is 1 and `txn_valid`, `rd_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 for a store burst, 0 for a load burst |
| req_port | input | PORT_W | Access-port number |
| req_addr | input | AW | Start byte address |
| req_count | input | CNT_W | Number of words |
| wd_valid | input | 1 | Store data word present |
| wd_ready | output | 1 | Store data word taken this cycle |
| wd_data | input | DW | Store data word |
| rd_valid | output | 1 | Load data word present |
| rd_ready | input | 1 | Consumer takes the load word |
| rd_data | output | DW | Load data word |
| txn_valid | output | 1 | Transaction offered to the engine |
| txn_ready | input | 1 | Engine accepts the transaction |
| txn_apndp | output | 1 | 1 for an access-port register, 0 for a debug-port register |
| txn_rnw | output | 1 | 1 for a read |
| txn_a | output | 2 | Register address bits [3:2] |
| txn_wdata | output | DW | Write payload |
| rsp_valid | input | 1 | Engine returns a response |
| rsp_ack | input | 3 | Acknowledge code |
| rsp_rdata | input | DW | Read result |
| done | output | 1 | Burst finished (one cycle) |
| done_status | output | 3 | Final acknowledge code |
| done_words | output | CNT_W | Words completed |

## Verification
Two events can fall in the same cycle: the done pulse of one burst and the acceptance of the next request. The bench provokes this by holding the next request valid through the end of a zero-count burst. It judges the overlap by sampling `req_ready` in the cycle in which `done` is high, and then by checking that the held request runs as a complete burst without a repeated select write. The second overlap is the hand-off of a held load word together with the decision on the next transaction. Load bursts run with `rd_ready` throttled, and the bench checks that every word arrives once and in address order while no transaction is offered.

// File: rtl/mem_burst_pkg.sv
package mem_burst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_TAR,
    ST_DATA,
    ST_RBUF,
    ST_PUSH
  } seq_state_t;

  localparam logic [2:0] ACK_OK     = 3'b001;
  localparam logic [1:0] A_SELECT   = 2'b10;
  localparam logic [1:0] A_XFERADDR = 2'b01;
  localparam logic [1:0] A_WINDOW   = 2'b11;
  localparam logic [1:0] A_RDBUF    = 2'b11;
  localparam logic [3:0] WIN_BANK   = 4'h0;
  localparam int         SEL_SHIFT  = 24;
endpackage

// File: rtl/mbs_sel_cache.sv
module mbs_sel_cache #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cand,
  input  logic          upd,
  output logic          hit
);
  logic [DW-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= '1;
    else if (upd) held_q <= cand;
  end

  assign hit = (held_q == cand);
endmodule

// File: rtl/mbs_rd_hold.sv
module mbs_rd_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mbs_txn_pack.sv
module mbs_txn_pack
  import mem_burst_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  seq_state_t    st,
  input  logic          pend,
  input  logic          is_wr,
  input  logic          sel_hit,
  input  logic          wd_valid,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] sel_val,
  input  logic [DW-1:0] wd_data,
  output logic          txn_valid,
  output logic          txn_apndp,
  output logic          txn_rnw,
  output logic [1:0]    txn_a,
  output logic [DW-1:0] txn_wdata
);
  always_comb begin
    txn_valid = 1'b0;
    txn_apndp = 1'b0;
    txn_rnw   = 1'b0;
    txn_a     = 2'b00;
    txn_wdata = '0;
    unique case (st)
      ST_SEL: begin
        txn_valid = !pend && !sel_hit;
        txn_a     = A_SELECT;
        txn_wdata = sel_val;
      end
      ST_TAR: begin
        txn_valid = !pend;
        txn_apndp = 1'b1;
        txn_a     = A_XFERADDR;
        txn_wdata = DW'(addr_q);
      end
      ST_DATA: begin
        txn_valid = !pend && (!is_wr || wd_valid);
        txn_apndp = 1'b1;
        txn_rnw   = !is_wr;
        txn_a     = A_WINDOW;
        txn_wdata = is_wr ? wd_data : '0;
      end
      ST_RBUF: begin
        txn_valid = !pend;
        txn_rnw   = 1'b1;
        txn_a     = A_RDBUF;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mem_burst_seq.sv
module mem_burst_seq
  import mem_burst_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 32,
  parameter int PORT_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PORT_W-1:0] req_port,
  input  logic [AW-1:0]     req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [DW-1:0]     wd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DW-1:0]     rd_data,
  output logic              txn_valid,
  input  logic              txn_ready,
  output logic              txn_apndp,
  output logic              txn_rnw,
  output logic [1:0]        txn_a,
  output logic [DW-1:0]     txn_wdata,
  input  logic              rsp_valid,
  input  logic [2:0]        rsp_ack,
  input  logic [DW-1:0]     rsp_rdata,
  output logic              done,
  output logic [2:0]        done_status,
  output logic [CNT_W-1:0]  done_words
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_t        st, push_ret;
  logic              pend, is_wr, first;
  logic [PORT_W-1:0] port_q;
  logic [AW-1:0]     addr_q;
  logic [CNT_W-1:0]  left, words;
  logic [DW-1:0]     sel_val;
  logic              sel_hit, rsp_take, rsp_ok, cache_upd, hold_load;

  assign sel_val   = (DW'(port_q) << SEL_SHIFT) | DW'({WIN_BANK, 4'h0});
  assign rsp_take  = pend && rsp_valid;
  assign rsp_ok    = rsp_ack == ACK_OK;
  assign cache_upd = rsp_take && rsp_ok && (st == ST_SEL);
  assign hold_load = rsp_take && rsp_ok &&
                     ((st == ST_RBUF) || (st == ST_DATA && !is_wr && !first));
  assign req_ready = (st == ST_IDLE);
  assign wd_ready  = (st == ST_DATA) && is_wr && !pend && txn_ready;

  mbs_sel_cache #(.DW(DW)) u_cache (
    .clk(clk), .rst_n(rst_n), .cand(sel_val), .upd(cache_upd), .hit(sel_hit)
  );

  mbs_rd_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(hold_load), .load_data(rsp_rdata),
    .out_valid(rd_valid), .out_ready(rd_ready), .out_data(rd_data)
  );

  mbs_txn_pack #(.DW(DW), .AW(AW)) u_pack (
    .st(st), .pend(pend), .is_wr(is_wr), .sel_hit(sel_hit),
    .wd_valid(wd_valid), .addr_q(addr_q), .sel_val(sel_val), .wd_data(wd_data),
    .txn_valid(txn_valid), .txn_apndp(txn_apndp), .txn_rnw(txn_rnw),
    .txn_a(txn_a), .txn_wdata(txn_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      push_ret    <= ST_IDLE;
      pend        <= 1'b0;
      is_wr       <= 1'b0;
      first       <= 1'b0;
      port_q      <= '0;
      addr_q      <= '0;
      left        <= '0;
      words       <= '0;
      done        <= 1'b0;
      done_status <= ACK_OK;
      done_words  <= '0;
    end else begin
      done <= 1'b0;
      if (txn_valid && txn_ready) pend <= 1'b1;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          is_wr  <= req_write;
          port_q <= req_port;
          addr_q <= req_addr;
          left   <= req_count;
          words  <= '0;
          first  <= 1'b1;
          if (req_count == '0) begin
            done        <= 1'b1;
            done_status <= ACK_OK;
            done_words  <= '0;
          end else begin
            st <= ST_SEL;
          end
        end
        ST_PUSH: if (rd_valid && rd_ready) begin
          words <= words + ONE;
          if (push_ret == ST_IDLE) begin
            st          <= ST_IDLE;
            done        <= 1'b1;
            done_status <= ACK_OK;
            done_words  <= words + ONE;
          end else begin
            st <= push_ret;
          end
        end
        default: begin
          if (st == ST_SEL && !pend && sel_hit) begin
            st <= ST_TAR;
          end else if (rsp_take) begin
            pend <= 1'b0;
            if (!rsp_ok) begin
              st          <= ST_IDLE;
              done        <= 1'b1;
              done_status <= rsp_ack;
              done_words  <= words;
            end else if (st == ST_SEL) begin
              st <= ST_TAR;
            end else if (st == ST_TAR) begin
              st <= ST_DATA;
            end else if (st == ST_RBUF) begin
              st       <= ST_PUSH;
              push_ret <= ST_IDLE;
            end else if (is_wr) begin
              left  <= left - ONE;
              words <= words + ONE;
              if (left == ONE) begin
                st          <= ST_IDLE;
                done        <= 1'b1;
                done_status <= ACK_OK;
                done_words  <= words + ONE;
              end
            end else begin
              left  <= left - ONE;
              first <= 1'b0;
              if (first) begin
                if (left == ONE) st <= ST_RBUF;
              end else begin
                st       <= ST_PUSH;
                push_ret <= (left == ONE) ? ST_RBUF : ST_DATA;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mem_burst_seq_chk.sv
module mem_burst_seq_chk #(
  parameter int DW     = 32,
  parameter int CNT_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             wd_valid,
  input logic             wd_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [DW-1:0]    rd_data,
  input logic             txn_valid,
  input logic             txn_ready,
  input logic             txn_apndp,
  input logic             txn_rnw,
  input logic [1:0]       txn_a,
  input logic [DW-1:0]    txn_wdata,
  input logic             rsp_valid,
  input logic [2:0]       rsp_ack,
  input logic             done,
  input logic [2:0]       done_status,
  input logic [CNT_W-1:0] done_words
);
  assert_txn_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_a) && $stable(txn_apndp)
                              && $stable(txn_rnw) && $stable(txn_wdata));

  assert_wd_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid && wd_ready |-> txn_valid && txn_ready && txn_apndp && !txn_rnw
                             && txn_a == 2'b11);

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  assert_no_issue_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !txn_valid);

  assert_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);

  assert_fail_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_status != 3'b001 |-> $past(rsp_valid) && $past(rsp_ack) == done_status);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  logic unused_ok;
  assign unused_ok = ^done_words;
endmodule

bind mem_burst_seq mem_burst_seq_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/mem_burst_seq_bench.sv
module mem_burst_seq_bench;
  localparam int DW = 32, AW = 32, PW = 8, CW = 8;

  typedef struct packed {
    logic       wr;
    logic [7:0] ap;
    logic [3:0] idx;
    logic [3:0] cnt;
    logic [3:0] fail_at;
    logic [2:0] fail_ack;
    logic       stall;
    logic       exp_sel;
    logic [2:0] exp_st;
    logic [3:0] exp_words;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b0, 8'd0, 4'd0,  4'd3, 4'd15, 3'b001, 1'b0, 1'b1, 3'b001, 4'd3},
    '{1'b1, 8'd0, 4'd4,  4'd4, 4'd15, 3'b001, 1'b0, 1'b0, 3'b001, 4'd4},
    '{1'b0, 8'd2, 4'd8,  4'd1, 4'd15, 3'b001, 1'b1, 1'b1, 3'b001, 4'd1},
    '{1'b1, 8'd2, 4'd2,  4'd0, 4'd15, 3'b001, 1'b0, 1'b0, 3'b001, 4'd0},
    '{1'b1, 8'd1, 4'd0,  4'd3, 4'd0,  3'b100, 1'b0, 1'b1, 3'b100, 4'd0},
    '{1'b1, 8'd1, 4'd0,  4'd2, 4'd3,  3'b010, 1'b0, 1'b1, 3'b010, 4'd1},
    '{1'b0, 8'd1, 4'd12, 4'd2, 4'd2,  3'b111, 1'b0, 1'b0, 3'b111, 4'd0},
    '{1'b0, 8'd1, 4'd3,  4'd4, 4'd15, 3'b001, 1'b1, 1'b0, 3'b001, 4'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [PW-1:0] req_port = '0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic wd_valid = 1'b0, wd_ready;
  logic [DW-1:0] wd_data = '0;
  logic rd_valid, rd_ready = 1'b1;
  logic [DW-1:0] rd_data;
  logic txn_valid, txn_ready = 1'b1, txn_apndp, txn_rnw;
  logic [1:0] txn_a;
  logic [DW-1:0] txn_wdata;
  logic rsp_valid = 1'b0;
  logic [2:0] rsp_ack = 3'b001;
  logic [DW-1:0] rsp_rdata = '0;
  logic done;
  logic [2:0] done_status;
  logic [CW-1:0] done_words;

  always #10 clk = ~clk;

  mem_burst_seq #(.DW(DW), .AW(AW), .PORT_W(PW), .CNT_W(CW)) u_mem_burst_seq (.*);

  int n_tests = 0, n_fail = 0;
  logic [31:0] mem [0:15];
  logic [31:0] tar, posted, last_sel, tar_val, r_dat;
  logic [2:0]  r_ack;
  int tx_idx, n_sel, n_tar, n_drw, n_bad;
  logic [3:0] fail_at = 4'd15;
  logic [2:0] fail_ack = 3'b001;
  logic stall = 1'b0, wr_en = 1'b0, hs;
  int wr_seq = 0;
  logic [31:0] rcap [0:15];
  int rn, dn;
  logic [2:0] d_st;
  logic [CW-1:0] d_words;
  logic d_rdy;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // target model with posted access-port reads and address auto-increment
  initial begin
    tar = '0; posted = 32'h0BAD_0BAD; last_sel = '0; tar_val = '0;
    for (int i = 0; i < 16; i++) mem[i] = 32'hA5A5_0000 + 32'(i) * 32'h111;
    forever begin
      @(negedge clk);
      if (rst_n && txn_valid && txn_ready) begin
        r_ack = (4'(tx_idx) == fail_at) ? fail_ack : 3'b001;
        r_dat = 32'hDEAD_BEEF;
        tx_idx++;
        if (!txn_apndp && !txn_rnw && txn_a == 2'b10) begin
          n_sel++;
          last_sel = txn_wdata;
        end else if (txn_apndp && !txn_rnw && txn_a == 2'b01) begin
          n_tar++;
          tar_val = txn_wdata;
          if (r_ack == 3'b001) tar = txn_wdata;
        end else if (txn_apndp && txn_a == 2'b11) begin
          n_drw++;
          if (r_ack == 3'b001) begin
            if (txn_rnw) begin
              r_dat = posted;
              posted = mem[tar[5:2]];
            end else begin
              mem[tar[5:2]] = txn_wdata;
            end
            tar = tar + 32'd4;
          end
        end else if (!txn_apndp && txn_rnw && txn_a == 2'b11) begin
          r_dat = posted;
        end else begin
          n_bad++;
        end
        @(posedge clk); #1;
        rsp_valid = 1'b1; rsp_ack = r_ack; rsp_rdata = r_dat;
        @(posedge clk); #1;
        rsp_valid = 1'b0;
      end
    end
  end

  // store data source
  initial forever begin
    @(negedge clk);
    hs = wd_valid && wd_ready;
    @(posedge clk); #1;
    if (hs) wr_seq++;
    wd_valid = wr_en;
    wd_data  = 32'h5EED_0000 + 32'(wr_seq);
  end

  // load data sink with optional throttling
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      k++;
      rd_ready = !stall || (k % 3 == 2);
    end
  end

  // output monitor
  initial forever begin
    @(negedge clk);
    if (rd_valid && rd_ready && rn < 16) begin
      rcap[rn] = rd_data;
      rn++;
    end
    if (done) begin
      dn++;
      d_st = done_status;
      d_words = done_words;
      d_rdy = req_ready;
    end
  end

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic clear_counts();
    tx_idx = 0; n_sel = 0; n_tar = 0; n_drw = 0; n_bad = 0; rn = 0; dn = 0;
  endtask

  task automatic issue(input logic w, input logic [7:0] ap, input logic [3:0] idx,
                       input logic [3:0] cnt);
    req_valid = 1'b1; req_write = w; req_port = ap;
    req_addr = {26'd0, idx, 2'b00}; req_count = CW'(cnt);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    for (int k = 0; k < 3000 && dn == 0; k++) @(negedge clk);
    chk({tag, " done seen"}, 32'(dn > 0), 32'd1);
  endtask

  task automatic run_vec(input vec_t v, input int n);
    logic [31:0] snap [0:15];
    int seq0;
    string t;
    t = $sformatf("vec%0d", n);
    @(posedge clk); #1;
    clear_counts();
    fail_at = v.fail_at; fail_ack = v.fail_ack; stall = v.stall;
    seq0 = wr_seq; wr_en = v.wr;
    for (int i = 0; i < 16; i++) snap[i] = mem[i];
    issue(v.wr, v.ap, v.idx, v.cnt);
    wait_done(t);
    wr_en = 1'b0; stall = 1'b0;
    repeat (2) @(negedge clk);
    chk({t, " R8 status"}, 32'(d_st), 32'(v.exp_st));
    chk({t, " R8 words"}, 32'(d_words), 32'(v.exp_words));
    chk({t, " R1 R2 R3 select writes"}, 32'(n_sel), 32'(v.exp_sel));
    if (n_sel > 0) chk({t, " R1 select value"}, last_sel, {v.ap, 24'h0});
    chk({t, " R5 encoding"}, 32'(n_bad), 32'd0);
    chk({t, " R10 ready at done"}, 32'(d_rdy), 32'd1);
    if (v.cnt == 0) chk({t, " R9 no transactions"}, 32'(tx_idx), 32'd0);
    if (n_tar > 0) chk({t, " R4 start address"}, tar_val, {26'd0, v.idx, 2'b00});
    if (v.exp_st == 3'b001 && v.cnt != 0) begin
      chk({t, " R4 one address write"}, 32'(n_tar), 32'd1);
      chk({t, " R4 window accesses"}, 32'(n_drw), 32'(v.cnt));
    end
    if (v.wr) begin
      for (int i = 0; i < 16; i++)
        if (i < int'(v.exp_words))
          chk({t, " R6 stored word"}, mem[(int'(v.idx) + i) % 16], 32'h5EED_0000 + 32'(seq0 + i));
    end else begin
      chk({t, " R7 words delivered"}, 32'(rn), 32'(v.exp_words));
      for (int i = 0; i < 16; i++)
        if (i < rn) chk({t, " R7 load word"}, rcap[i], snap[(int'(v.idx) + i) % 16]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R11 req_ready", 32'(req_ready), 32'd1);
    chk("R11 txn_valid", 32'(txn_valid), 32'd0);
    chk("R11 rd_valid", 32'(rd_valid), 32'd0);
    chk("R11 done", 32'(done), 32'd0);

    for (int n = 0; n < 8; n++) run_vec(VECS[n], n);

    // R10: a held request is taken in the cycle of the previous done pulse
    @(posedge clk); #1;
    clear_counts();
    fail_at = 4'd15;
    req_valid = 1'b1; req_write = 1'b1; req_port = 8'd1; req_addr = '0; req_count = '0;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_write = 1'b0; req_addr = 32'd20; req_count = CW'(1);
    @(negedge clk);
    chk("R10 done with held request", 32'(done && req_ready), 32'd1);
    chk("R9 zero count status", 32'(done_status), 32'b001);
    @(posedge clk); #1;
    req_valid = 1'b0; dn = 0;
    wait_done("R10 second burst");
    repeat (2) @(negedge clk);
    chk("R10 second burst status", 32'(d_st), 32'b001);
    chk("R10 second burst word", rcap[0], mem[5]);
    chk("R1 cached port skips select", 32'(n_sel), 32'd0);

    // R2: reset invalidates the cached select copy
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    clear_counts();
    issue(1'b0, 8'd1, 4'd6, 4'd1);
    wait_done("R2 after reset");
    repeat (2) @(negedge clk);
    chk("R2 select rewritten after reset", 32'(n_sel), 32'd1);
    chk("R2 load word", rcap[0], mem[6]);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule